// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small stored-program processor built around one accumulator register. Instructions and data share one word-addressed on-chip memory. Each instruction word carries an operation code and one memory address. The control unit repeats the same three steps. It fetches the word that the program counter points at into an instruction register. It decodes the operation code. It then executes the instruction, which is a data transfer, an arithmetic step, a comparison or a jump. The loop ends when a halt instruction executes.

The ALU computes every candidate result at once, and a selector driven by the decoded operation picks the one that is kept. A comparison records its outcome in a three-flag condition register. The conditional jumps read those flags. A host port owns the memory while the processor is held in reset or has halted. The host uses it to load a program and data before a run and to read results after one.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, the program counter, the accumulator and the condition flags read zero, and `halted_o` is low.
- R2: An instruction word has the operation in bits 15:12 and the address X in bits 11:0. The program counter advances by one as each word is fetched, so instructions run in address order and a taken jump replaces the advanced value.
- R3: Operation 0 (load) copies memory word X into the accumulator. Operation 1 (store) copies the accumulator into memory word X.
- R4: Operation 3 (add) sets the accumulator to the accumulator plus word X. Operation 5 (subtract) sets it to the accumulator minus word X. Both wrap modulo 2^16, and neither changes the condition flags.
- R5: Operation 2 zeroes the accumulator, operation 4 adds one to it and operation 6 subtracts one from it, each without a memory access.
- R6: Operation 7 (compare) leaves exactly one flag set on `cond_o` = {gt, eq, lt}. The flag is 3'b100 when word X is greater than the accumulator, 3'b010 when they are equal and 3'b001 when word X is smaller, all compared unsigned.
- R7: Operation 8 always loads the program counter with X.
- R8: Operations 9, 10 and 11 load the program counter with X only when gt, eq or lt is set, respectively. Operation 12 does so when gt or eq is set, and operation 13 when lt or eq is set. Otherwise execution continues with the next word.
- R9: Operation 15 (halt) raises `halted_o`. From then on the program counter, the accumulator and the flags no longer change, and the program counter holds the halt address plus one.
- R10: Operation 14 changes neither the accumulator nor the flags nor memory, and execution goes on with the next word.
- R11: While `rst` is high or `halted_o` is set, `host_we` writes `host_wdata` to word `host_addr`. `host_rdata` returns the word at `host_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also hands memory to the host |
| host_we | input | 1 | Host write enable, honoured in reset or halt |
| host_addr | input | MEM_AW | Host word address |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Registered read data for the host address |
| halted_o | output | 1 | Processor has executed a halt |
| pc_o | output | WORD_W-4 | Program counter |
| acc_o | output | WORD_W | Accumulator |
| cond_o | output | 3 | Condition flags {gt, eq, lt} |

## Verification
The hardest behaviour to reach from the ports is a conditional jump taken or skipped for every flag pattern. The flags exist only as the result of a comparison that a running program performs, so no input can set them directly. The bench therefore builds one short program for each pairing of the six jump operations with the three compare outcomes. Each program compares a loaded value against a smaller, an equal and a larger memory word, and the jump then steers it to one of two store-and-halt tails. The word stored and the final program counter show which path ran, and a counted loop that closes on a backward jump covers repeated branching.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 4'd0,  OP_STORE = 4'd1,  OP_CLEAR = 4'd2,  OP_ADD   = 4'd3,
    OP_INC   = 4'd4,  OP_SUB   = 4'd5,  OP_DEC   = 4'd6,  OP_CMP   = 4'd7,
    OP_JMP   = 4'd8,  OP_JGT   = 4'd9,  OP_JEQ   = 4'd10, OP_JLT   = 4'd11,
    OP_JGE   = 4'd12, OP_JLE   = 4'd13, OP_SPARE = 4'd14, OP_HALT  = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEMOP, ST_HALT
  } state_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cond_t;

  // operations that need a memory word read in a second execute cycle
  function automatic logic reads_operand(opcode_e op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  endfunction

  // operations that update the accumulator without memory
  function automatic logic acc_only(opcode_e op);
    return (op == OP_CLEAR) || (op == OP_INC) || (op == OP_DEC);
  endfunction
endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DATA_W = 16,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DATA_W-1:0] ram [DEPTH];

  // single port, read-before-write, registered read
  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  opcode_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mdata,
  output logic [W-1:0] res,
  output cond_t        cmp
);
  logic [W-1:0] sum, diff, incr, decr;

  // every unit works on every cycle; the selector keeps one answer
  assign sum  = acc + mdata;
  assign diff = acc - mdata;
  assign incr = acc + W'(1);
  assign decr = acc - W'(1);

  assign cmp.gt = (mdata > acc);
  assign cmp.eq = (mdata == acc);
  assign cmp.lt = (mdata < acc);

  always_comb begin
    case (op)
      OP_LOAD:  res = mdata;
      OP_ADD:   res = sum;
      OP_SUB:   res = diff;
      OP_INC:   res = incr;
      OP_DEC:   res = decr;
      OP_CLEAR: res = '0;
      default:  res = acc;
    endcase
  end
endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
  import acc_cpu_pkg::*;
(
  input  opcode_e op,
  input  cond_t   cond,
  output logic    take
);
  always_comb begin
    case (op)
      OP_JMP:  take = 1'b1;
      OP_JGT:  take = cond.gt;
      OP_JEQ:  take = cond.eq;
      OP_JLT:  take = cond.lt;
      OP_JGE:  take = cond.gt | cond.eq;
      OP_JLE:  take = cond.lt | cond.eq;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int MEM_AW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_we,
  input  logic [MEM_AW-1:0]    host_addr,
  input  logic [WORD_W-1:0]    host_wdata,
  output logic [WORD_W-1:0]    host_rdata,
  output logic                 halted_o,
  output logic [WORD_W-OP_W-1:0] pc_o,
  output logic [WORD_W-1:0]    acc_o,
  output logic [2:0]           cond_o
);
  localparam int ADDR_W = WORD_W - OP_W;

  state_e              state;
  logic [ADDR_W-1:0]   pc;
  logic [WORD_W-1:0]   ir;
  logic [WORD_W-1:0]   acc;
  cond_t               cond;

  opcode_e             op;
  logic [ADDR_W-1:0]   ir_addr;
  logic                host_owns;
  logic                mem_we;
  logic [MEM_AW-1:0]   mem_addr;
  logic [WORD_W-1:0]   mem_wdata;
  logic [WORD_W-1:0]   mem_rdata;
  logic [WORD_W-1:0]   alu_res;
  cond_t               alu_cmp;
  logic                take;

  assign op      = opcode_e'(ir[WORD_W-1 -: OP_W]);
  assign ir_addr = ir[ADDR_W-1:0];

  // memory port arbitration: host while held or stopped, core otherwise
  assign host_owns = rst || (state == ST_HALT);
  always_comb begin
    if (host_owns) begin
      mem_we    = host_we;
      mem_addr  = host_addr;
      mem_wdata = host_wdata;
    end else begin
      mem_we    = (state == ST_EXEC) && (op == OP_STORE);
      mem_addr  = (state == ST_FETCH) ? pc[MEM_AW-1:0] : ir_addr[MEM_AW-1:0];
      mem_wdata = acc;
    end
  end

  acc_cpu_mem #(.DATA_W(WORD_W), .AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  acc_cpu_alu #(.W(WORD_W)) u_alu (
    .op(op), .acc(acc), .mdata(mem_rdata), .res(alu_res), .cmp(alu_cmp)
  );

  acc_cpu_branch u_branch (.op(op), .cond(cond), .take(take));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
      acc   <= '0;
      cond  <= '0;
    end else begin
      case (state)
        ST_FETCH: begin
          pc    <= pc + ADDR_W'(1);
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          ir    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op == OP_HALT) begin
            state <= ST_HALT;
          end else if (reads_operand(op)) begin
            state <= ST_MEMOP;
          end else begin
            if (acc_only(op)) acc <= alu_res;
            if (take) pc <= ir_addr;
            state <= ST_FETCH;
          end
        end
        ST_MEMOP: begin
          if (op == OP_CMP) cond <= alu_cmp;
          else              acc  <= alu_res;
          state <= ST_FETCH;
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_FETCH;
      endcase
    end
  end

  assign host_rdata = mem_rdata;
  assign halted_o   = (state == ST_HALT);
  assign pc_o       = pc;
  assign acc_o      = acc;
  assign cond_o     = cond;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input state_e            state,
  input opcode_e           op,
  input logic [ADDR_W-1:0] ir_addr,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] acc,
  input logic [2:0]        cond,
  input logic              halted
);
  // R2: every fetch moves the program counter on by one
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> pc == $past(pc) + ADDR_W'(1));

  // R4: add and subtract leave the flags alone
  p_arith_keeps_cond_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEMOP && (op == OP_ADD || op == OP_SUB)) |=> $stable(cond));

  // R6: a compare leaves exactly one flag set
  p_cmp_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEMOP && op == OP_CMP) |=> $countones(cond) == 1);

  // R7: unconditional jump lands on its address field
  p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op == OP_JMP) |=> pc == $past(ir_addr));

  // R9: once stopped, nothing architectural moves
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && $stable(acc) && $stable(cond));

  // R10: the spare operation is inert
  p_spare_inert_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op == OP_SPARE) |=> $stable(acc) && $stable(cond) && state == ST_FETCH);
endmodule

bind acc_cpu acc_cpu_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .state(state), .op(op), .ir_addr(ir_addr),
  .pc(pc), .acc(acc), .cond(cond_o), .halted(halted_o)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
  localparam int WORD_W = 16;
  localparam int MEM_AW = 8;
  localparam int DEPTH  = 2 ** MEM_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_we = 1'b0;
  logic [MEM_AW-1:0] host_addr = '0;
  logic [WORD_W-1:0] host_wdata = '0;
  logic [WORD_W-1:0] host_rdata;
  logic              halted_o;
  logic [11:0]       pc_o;
  logic [WORD_W-1:0] acc_o;
  logic [2:0]        cond_o;

  int tests = 0;
  int fails = 0;

  typedef struct { int addr; logic [15:0] val; string req; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  acc_cpu #(.WORD_W(WORD_W), .MEM_AW(MEM_AW)) i_acc_cpu (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .halted_o(halted_o),
    .pc_o(pc_o), .acc_o(acc_o), .cond_o(cond_o)
  );

  function automatic logic [15:0] ins(int op, int a);
    return {op[3:0], a[11:0]};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic poke(int a, logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a[MEM_AW-1:0]; host_wdata = d;
  endtask

  task automatic peek(int a, output logic [15:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = a[MEM_AW-1:0];
    @(negedge clk);
    d = host_rdata;
  endtask

  // hold reset, wipe memory
  task automatic prepare();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) poke(i, 16'h0000);
  endtask

  task automatic run();
    int n;
    @(negedge clk);
    host_we = 1'b0;
    rst = 1'b0;
    n = 0;
    while (!halted_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted_o) begin
      tests++; fails++;
      $display("FAIL R9 program never halted: actual 0 expected 1");
    end
  endtask

  // scoreboard: driver side queues expectations
  task automatic expect_mem(int a, logic [15:0] v, string req);
    exp_t e;
    e.addr = a; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  // monitor side: drain the queue against the memory the design left
  task automatic drain();
    logic [15:0] d;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      peek(e.addr, d);
      chk(e.req, $sformatf("mem[%0h]", e.addr), {16'h0, d}, {16'h0, e.val});
    end
  endtask

  function automatic bit taken(int j, bit g, bit e, bit l);
    case (j)
      8:  return 1'b1;
      9:  return g;
      10: return e;
      11: return l;
      12: return g | e;
      13: return l | e;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;

    // ---------------- program 1: transfer, arithmetic, spare op
    prepare();
    chk("R1", "pc in reset", {20'h0, pc_o}, 32'h0);
    chk("R1", "acc in reset", {16'h0, acc_o}, 32'h0);
    chk("R1", "cond in reset", {29'h0, cond_o}, 32'h0);
    chk("R1", "halted in reset", {31'h0, halted_o}, 32'h0);
    poke(0,  ins(0, 'h80));   // R3 load 5
    poke(1,  ins(3, 'h81));   // R4 add 7 -> 12
    poke(2,  ins(1, 'h90));
    poke(3,  ins(5, 'h82));   // R4 minus 20 -> FFF8
    poke(4,  ins(1, 'h91));
    poke(5,  ins(4, 0));      // R5 -> FFF9
    poke(6,  ins(1, 'h92));
    poke(7,  ins(6, 0));
    poke(8,  ins(6, 0));      // -> FFF7
    poke(9,  ins(14, 'h90));  // R10 spare op pointing at a data word
    poke(10, ins(1, 'h93));
    poke(11, ins(3, 'h83));   // + 10 wraps -> 0001
    poke(12, ins(1, 'h95));
    poke(13, ins(2, 0));      // clear
    poke(14, ins(1, 'h94));
    poke(15, ins(7, 'h80));   // 5 > 0 -> gt
    poke(16, ins(3, 'h80));   // acc 5, flags kept
    poke(17, ins(15, 0));
    poke('h80, 16'd5);
    poke('h81, 16'd7);
    poke('h82, 16'd20);
    poke('h83, 16'd10);
    poke('h94, 16'hBEEF);
    run();
    expect_mem('h90, 16'd12,   "R4");
    expect_mem('h91, 16'hFFF8, "R4");
    expect_mem('h92, 16'hFFF9, "R5");
    expect_mem('h93, 16'hFFF7, "R10");
    expect_mem('h95, 16'h0001, "R4");
    expect_mem('h94, 16'h0000, "R5");
    expect_mem('h80, 16'd5,    "R3");
    chk("R4", "acc after add with kept flags", {16'h0, acc_o}, 32'd5);
    chk("R6", "cond after compare then add", {29'h0, cond_o}, 32'b100);
    chk("R9", "pc at halt", {20'h0, pc_o}, 32'd18);
    drain();
    repeat (20) @(negedge clk);
    chk("R9", "pc frozen", {20'h0, pc_o}, 32'd18);
    chk("R9", "acc frozen", {16'h0, acc_o}, 32'd5);
    chk("R9", "still halted", {31'h0, halted_o}, 32'd1);
    // R11: host writes while halted
    poke('hA0, 16'h5A5A);
    peek('hA0, d);
    chk("R11", "host write while halted", {16'h0, d}, 32'h5A5A);

    // ---------------- branch matrix: six jumps x three outcomes
    for (int j = 8; j <= 13; j++) begin
      for (int r = 0; r < 3; r++) begin
        logic [15:0] b;
        bit g, e, l, t;
        b = (r == 0) ? 16'd40 : (r == 1) ? 16'd50 : 16'd60;
        g = (b > 16'd50); e = (b == 16'd50); l = (b < 16'd50);
        t = taken(j, g, e, l);
        prepare();
        poke(0, ins(0, 'h80));
        poke(1, ins(7, 'h81));
        poke(2, ins(j, 6));
        poke(3, ins(0, 'h82));
        poke(4, ins(1, 'h90));
        poke(5, ins(15, 0));
        poke(6, ins(0, 'h83));
        poke(7, ins(1, 'h90));
        poke(8, ins(15, 0));
        poke('h80, 16'd50);
        poke('h81, b);
        poke('h82, 16'h1111);
        poke('h83, 16'h2222);
        run();
        chk("R6", $sformatf("flags op%0d b=%0d", j, b), {29'h0, cond_o}, {29'h0, g, e, l});
        chk(j == 8 ? "R7" : "R8", $sformatf("pc op%0d b=%0d", j, b),
            {20'h0, pc_o}, t ? 32'd9 : 32'd6);
        expect_mem('h90, t ? 16'h2222 : 16'h1111, j == 8 ? "R7" : "R8");
        drain();
      end
    end

    // ---------------- counted loop with a backward jump
    prepare();
    poke(0, ins(2, 0));
    poke(1, ins(4, 0));
    poke(2, ins(1, 'h90));
    poke(3, ins(7, 'h80));
    poke(4, ins(9, 1));       // loop while limit > acc
    poke(5, ins(15, 0));
    poke('h80, 16'd5);
    run();
    chk("R8", "loop final acc", {16'h0, acc_o}, 32'd5);
    chk("R6", "loop final flags eq", {29'h0, cond_o}, 32'b010);
    chk("R2", "loop final pc", {20'h0, pc_o}, 32'd6);
    expect_mem('h90, 16'd5, "R3");
    drain();

    // R1 again after a run, then R11 read while held in reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc cleared by reset", {20'h0, pc_o}, 32'h0);
    chk("R1", "acc cleared by reset", {16'h0, acc_o}, 32'h0);
    peek('h90, d);
    chk("R11", "host read in reset", {16'h0, d}, 32'd5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule